// File: doc/BRIEF.md
# Programmable scaled clock-enable generator

This block divides an incoming clock-enable pulse stream by a software-programmed amount. The incoming pulses (clock A) come from an upstream prescaler. Every qualifying input pulse advances an internal down-counter. The block issues a one-cycle output enable (clock SA) once for every two times the scale value of effective input pulses. A scale value of zero stands for 256, which gives a division of 512.

A small write port holds the 8-bit scale value and a two-bit gating control word. Each gating bit, when set, lets a core-state input (doze or debug halt) freeze the division. While frozen, input pulses are ignored and the counter state is held. The block also asserts a hold output so that the upstream prescaler can stop. When gating lifts, counting resumes from the held state.

Any write to the scale value reloads the counter at once and restarts the division, even when the value written equals the current one.

Top module: `scaled_clk_gen`

## Requirements
- R1: After reset, `clksa_en_o` and `presc_hold_o` are 0, the scale value is 0, both gating bits are 0, and the first output pulse follows 512 input pulses.
- R2: With scale value S in 1..255, `clksa_en_o` pulses once per 2*S effective input pulses. The pulse appears in the cycle after the clock edge that accepts the 2*S-th pulse.
- R3: A scale value of 0 gives one output pulse per 512 effective input pulses.
- R4: Each output pulse lasts exactly one cycle and only follows a cycle in which an effective input pulse was accepted.
- R5: A write with `wr_addr_i`=0 loads the scale value and restarts the division. The next pulse comes 2*S effective input pulses after the write, and an input pulse in the writing cycle is not counted. This holds even when the same value is rewritten.
- R6: Control bit 0 (written with `wr_addr_i`=1) enables doze gating. While it is 1 and `doze_i`=1, `presc_hold_o`=1 in the same cycle and input pulses are ignored. While it is 0, `doze_i` has no effect.
- R7: Control bit 1 enables debug gating. While it is 1 and `debug_i`=1, `presc_hold_o`=1 and input pulses are ignored. While it is 0, `debug_i` has no effect.
- R8: When gating ends, division resumes from the held counter and phase state, so the total count of effective pulses between output pulses stays 2*S.
- R9: A control write (`wr_addr_i`=1) does not change the division phase or the scale value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clka_en_i | input | 1 | Incoming prescaled enable pulse (clock A) |
| doze_i | input | 1 | Core is in doze state |
| debug_i | input | 1 | Core is in debug halt |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects the scale value, 1 selects the control bits |
| wr_data_i | input | 8 | Write data |
| clksa_en_o | output | 1 | Scaled enable pulse (clock SA) |
| presc_hold_o | output | 1 | Gating is active; the upstream prescaler should stop |

## Verification
The assertions take for granted that register writes are single-cycle strobes and that `clka_en_i` is sampled only on clock edges. They need no spacing between input pulses, because the scale value is never below 1 and so two output pulses cannot be adjacent. The bench holds every input stable across each edge. It drives pulses as dense streams, as sparse periodic patterns and together with writes in the same cycle. It checks every cycle against a model that counts effective pulses and expects an output at each multiple of twice the scale value.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic {
    ADDR_SCALE = 1'b0,
    ADDR_CTRL  = 1'b1
  } scl_addr_e;

  localparam int unsigned N_GATE       = 2;
  localparam int unsigned CTRL_DOZE_BIT = 0;
  localparam int unsigned CTRL_DBG_BIT  = 1;
endpackage

// File: rtl/scl_regs.sv
module scl_regs
  import scl_pkg::*;
#(
  parameter int unsigned SCALE_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_addr_i,
  input  logic [SCALE_W-1:0]   wr_data_i,
  output logic [SCALE_W-1:0]   scale_o,
  output logic [N_GATE-1:0]    gate_en_o,
  output logic                 scale_load_o
);
  logic [SCALE_W-1:0] scale_q;
  logic [N_GATE-1:0]  gate_en_q;
  logic               ctrl_wr;

  assign scale_load_o = wr_en_i && (wr_addr_i == ADDR_SCALE);
  assign ctrl_wr      = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_q <= '0;
    end else if (scale_load_o) begin
      scale_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_en_q <= '0;
    end else if (ctrl_wr) begin
      gate_en_q <= wr_data_i[N_GATE-1:0];
    end
  end

  assign scale_o   = scale_q;
  assign gate_en_o = gate_en_q;
endmodule

// File: rtl/scl_gate.sv
module scl_gate #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] gate_en_i,
  input  logic [N-1:0] gate_req_i,
  input  logic         tick_i,
  output logic         tick_o,
  output logic         hold_o
);
  logic [N-1:0] stop_vec;

  for (genvar g = 0; g < N; g++) begin : g_src
    assign stop_vec[g] = gate_en_i[g] & gate_req_i[g];
  end

  assign hold_o = |stop_vec;
  assign tick_o = tick_i & ~hold_o;
endmodule

// File: rtl/scl_div.sv
module scl_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] scale_i,
  output logic         pulse_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         half_q;
  logic         pulse_q;
  logic         term;

  assign term = (cnt_q == '0);

  // A load always wins over a tick arriving in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '1;
      half_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i - ONE;
      half_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (tick_i) begin
      if (term) begin
        cnt_q  <= scale_i - ONE;  // 0 wraps to all ones: divide by 2^W
        half_q <= ~half_q;
      end else begin
        cnt_q  <= cnt_q - ONE;
      end
      pulse_q <= term & half_q;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/scaled_clk_gen.sv
module scaled_clk_gen
  import scl_pkg::*;
#(
  parameter int unsigned SCALE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clka_en_i,
  input  logic               doze_i,
  input  logic               debug_i,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [SCALE_W-1:0] wr_data_i,
  output logic               clksa_en_o,
  output logic               presc_hold_o
);
  logic [SCALE_W-1:0] scale_q;
  logic [N_GATE-1:0]  gate_en;
  logic [N_GATE-1:0]  gate_req;
  logic               scale_load;
  logic               eff_tick;
  logic [SCALE_W-1:0] cnt_q;

  assign gate_req[CTRL_DOZE_BIT] = doze_i;
  assign gate_req[CTRL_DBG_BIT]  = debug_i;

  scl_regs #(.SCALE_W(SCALE_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .scale_o     (scale_q),
    .gate_en_o   (gate_en),
    .scale_load_o(scale_load)
  );

  scl_gate #(.N(N_GATE)) u_gate (
    .gate_en_i (gate_en),
    .gate_req_i(gate_req),
    .tick_i    (clka_en_i),
    .tick_o    (eff_tick),
    .hold_o    (presc_hold_o)
  );

  scl_div #(.W(SCALE_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (eff_tick),
    .load_i    (scale_load),
    .load_val_i(wr_data_i),
    .scale_i   (scale_q),
    .pulse_o   (clksa_en_o),
    .cnt_o     (cnt_q)
  );
endmodule

// File: rtl/scaled_clk_gen_chk.sv
module scaled_clk_gen_chk #(
  parameter int unsigned SCALE_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clka_en_i,
  input logic               doze_i,
  input logic               debug_i,
  input logic               wr_en_i,
  input logic               wr_addr_i,
  input logic               clksa_en_o,
  input logic               presc_hold_o,
  input logic [SCALE_W-1:0] scale_q,
  input logic [SCALE_W-1:0] cnt_q,
  input logic [1:0]         gate_en
);
  logic [SCALE_W-1:0] reload;
  assign reload = scale_q - SCALE_W'(1);

  // R4
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clksa_en_o |=> !clksa_en_o);

  // R4
  pulse_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clksa_en_o |-> $past(clka_en_i && !presc_hold_o && !(wr_en_i && !wr_addr_i)));

  // R6
  doze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en[0] && doze_i) |-> presc_hold_o);

  // R7
  debug_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en[1] && debug_i) |-> presc_hold_o);

  // R6
  hold_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_hold_o |-> ((gate_en[0] && doze_i) || (gate_en[1] && debug_i)));

  // R8
  frozen_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc_hold_o && !wr_en_i) |=> ($stable(cnt_q) && !clksa_en_o));

  // R5
  wr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_addr_i) |=> (!clksa_en_o && cnt_q == reload));

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= reload);

  // R9
  ctrl_wr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i) |=> $stable(scale_q));
endmodule

bind scaled_clk_gen scaled_clk_gen_chk #(.SCALE_W(SCALE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clka_en_i   (clka_en_i),
  .doze_i      (doze_i),
  .debug_i     (debug_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .clksa_en_o  (clksa_en_o),
  .presc_hold_o(presc_hold_o),
  .scale_q     (scale_q),
  .cnt_q       (cnt_q),
  .gate_en     (gate_en)
);

// File: tb/scaled_clk_gen_test.sv
module scaled_clk_gen_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clka_en_i = 1'b0;
  logic       doze_i = 1'b0;
  logic       debug_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_addr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       clksa_en_o;
  logic       presc_hold_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_scale = 256;
  int m_cnt = 0;
  bit m_dz = 1'b0;
  bit m_db = 1'b0;

  always #4 clk = ~clk;

  scaled_clk_gen uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .clka_en_i   (clka_en_i),
    .doze_i      (doze_i),
    .debug_i     (debug_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .clksa_en_o  (clksa_en_o),
    .presc_hold_o(presc_hold_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive after negedge, model at posedge, compare after next negedge.
  task automatic cyc(input string tag, input bit wr, input bit addr,
                     input logic [7:0] d, input bit tk, input bit dz, input bit db);
    bit hold;
    bit eff;
    bit exp_p;
    wr_en_i = wr; wr_addr_i = addr; wr_data_i = d;
    clka_en_i = tk; doze_i = dz; debug_i = db;
    hold = (m_dz && dz) || (m_db && db);
    #1;
    check({tag, " hold"}, presc_hold_o, hold);
    @(posedge clk);
    eff = tk && !hold;
    exp_p = 1'b0;
    if (wr && !addr) begin
      m_scale = (d == 0) ? 256 : int'(d);
      m_cnt = 0;
    end else if (eff) begin
      m_cnt++;
      exp_p = (m_cnt % (2 * m_scale)) == 0;
    end
    if (wr && addr) begin
      m_dz = d[0];
      m_db = d[1];
    end
    @(negedge clk);
    check({tag, " pulse"}, clksa_en_o, exp_p);
  endtask

  task automatic run(input string tag, input int n, input int every);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 8'h00, (i % every) == 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #3;
    check("R1 reset pulse", clksa_en_o, 1'b0);
    check("R1 reset hold", presc_hold_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1 / R3: reset scale 0 divides by 512
    run("R1", 1030, 1);

    // R2: dense sweep over scale values
    for (int s = 1; s <= 24; s++) begin
      cyc("R5 write", 1, 0, 8'(s), 0, 0, 0);
      run("R2 dense", 6 * s + 2, 1);
    end
    // R2: sparse input patterns
    for (int s = 1; s <= 8; s++) begin
      for (int e = 2; e <= 4; e++) begin
        cyc("R5 write", 1, 0, 8'(s), 0, 0, 0);
        run("R2 sparse", 4 * s * e + 3, e);
      end
    end
    cyc("R5 write", 1, 0, 8'd255, 0, 0, 0);
    run("R2 max", 1025, 1);
    // R3: scale 0 written explicitly
    cyc("R5 write", 1, 0, 8'd0, 0, 0, 0);
    run("R3", 1030, 1);

    // R5: rewrite the same value mid-period, with a pulse in the writing cycle
    cyc("R5 write", 1, 0, 8'd5, 1, 0, 0);
    run("R5", 7, 1);
    cyc("R5 same", 1, 0, 8'd5, 1, 0, 0);
    run("R5", 25, 1);

    // R9: control write mid-period does not disturb the division
    run("R9", 3, 1);
    cyc("R9 ctrl", 1, 1, 8'h00, 1, 0, 0);
    run("R9", 20, 1);

    // R6: doze gating off, doze has no effect
    cyc("R6 write", 1, 0, 8'd3, 0, 0, 0);
    for (int i = 0; i < 30; i++) cyc("R6 off", 0, 0, 8'h00, 1, 1, 1);
    // R6 / R8: doze gating on, alternating doze windows
    cyc("R6 ctrl", 1, 1, 8'h01, 1, 0, 0);
    for (int i = 0; i < 60; i++) cyc("R6 R8", 0, 0, 8'h00, 1, (i / 4) % 2 == 1, 1);
    // R7 / R8: debug gating only
    cyc("R7 ctrl", 1, 1, 8'h02, 1, 0, 0);
    for (int i = 0; i < 60; i++) cyc("R7 R8", 0, 0, 8'h00, 1, 1, (i / 5) % 2 == 1);
    // R6 R7: both enabled, mixed requests, sparse ticks
    cyc("R7 ctrl", 1, 1, 8'h03, 0, 0, 0);
    for (int i = 0; i < 80; i++) cyc("R6 R7", 0, 0, 8'h00, (i % 2) == 0, (i % 7) < 2, (i % 11) < 3);
    // R8: write during gating restarts, then resumes
    cyc("R8 write", 1, 0, 8'd2, 1, 1, 0);
    for (int i = 0; i < 30; i++) cyc("R8", 0, 0, 8'h00, 1, i < 10, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule